// File: doc/BRIEF.md
# Stack-Operand Nibble ALU

This block is the arithmetic and logic unit of a zero-address stack processor with a 4-bit data path. It has no operand address fields. Its two sources are always the top-of-stack nibble and the nibble directly beneath it. Its result always replaces the top-of-stack entry. An operation code picks one of fourteen functions. These fall into four groups: arithmetic, bitwise logic, shifts and rotates. Each operation updates two condition flags, carry/borrow and branch.

Surrounding sequencing logic presents the opcode, both stack nibbles and the current carry flag, and raises `op_valid` for one machine cycle. The result, the new flags, a flag write strobe and a pop request are all registered on the clock edge that ends that cycle. The stack control uses the pop request to drop one entry after a two-operand operation. Stack pointer handling, the RAM-backed deeper stack and instruction decode are outside this block.

Top module: `stk_alu4`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `res_out`, `carry_out`, `branch_out`, `flag_wr` and `pop_req` are all 0.
- R2: Opcode 0 gives {carry,result} = nos + tos. Opcode 1 gives {carry,result} = nos + tos + carry_in.
- R3: Opcode 2 gives result = nos − tos. Opcode 3 gives result = nos − tos − carry_in. In both cases carry is 1 exactly when the true difference is negative (a borrow).
- R4: Opcodes 4, 5 and 6 give nos AND tos, nos OR tos and nos XOR tos. Opcode 7 gives NOT tos. These four opcodes copy carry_in to carry unchanged.
- R5: Opcode 8 gives tos + 1, with carry set on wrap from 15 to 0. Opcode 9 gives tos − 1, with carry set on a borrow from 0 to 15.
- R6: Opcode 10 shifts tos left by one with a zero fill. Opcode 11 shifts tos right by one with a zero fill. In both, carry and branch take the bit shifted out.
- R7: Opcode 12 rotates left through carry: result = {tos[2:0], carry_in}, and carry = tos[3]. Opcode 13 rotates right through carry: result = {carry_in, tos[3:1]}, and carry = tos[0]. In both, branch equals the new carry.
- R8: For opcodes 0 to 9, branch is 1 exactly when the 4-bit result is zero.
- R9: `pop_req` pulses with the result of opcodes 0 to 6, which are the two-operand operations. It stays 0 for opcodes 7 to 13.
- R10: A result for opcodes 0 to 13 appears on the first rising edge at which `op_valid` is high. `flag_wr` is high for exactly that one cycle. While `op_valid` is low, the result and flags hold and neither strobe rises.
- R11: Opcodes 14 and 15 are reserved. With `op_valid` high they produce no strobe and leave the result and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the edge ends the machine cycle |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| tos_in | input | 4 | Top-of-stack nibble |
| nos_in | input | 4 | Nibble below the top of stack |
| carry_in | input | 1 | Current carry/borrow flag |
| res_out | output | 4 | Result to write into top of stack |
| carry_out | output | 1 | New carry/borrow flag |
| branch_out | output | 1 | New branch flag |
| flag_wr | output | 1 | One-cycle strobe: result and flags are valid |
| pop_req | output | 1 | One-cycle request to drop one stack entry |

## Verification
Every implemented opcode is driven back to back over all 256 operand pairs, once with carry-in clear and once with it set. This separates the carry-using forms (add with carry, subtract with borrow, rotates) from their carry-free forms, and it exposes operand order in subtraction. The sweep reaches the wrap points 15→0 and 0→15, the all-zero results that must raise branch, and the edge bits that shifts and rotates push into carry. Idle cycles and reserved opcodes placed between operations show whether the outputs hold and the strobes stay low.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOT  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_SHL  = 4'd10,
    OP_SHR  = 4'd11,
    OP_ROL  = 4'd12,
    OP_ROR  = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_SHIFT = 2'd2,
    CLS_NONE  = 2'd3
  } alu_cls_e;
endpackage

// File: rtl/stk_alu_arith.sv
module stk_alu_arith
  import stk_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    tos,
  input  logic [DW-1:0]    nos,
  input  logic             cin,
  output logic [DW-1:0]    res,
  output logic             cout
);
  localparam logic [DW:0] ONE = {{DW{1'b0}}, 1'b1};
  logic [DW:0] ext_t, ext_n, ext_c, acc;

  always_comb begin
    ext_t = {1'b0, tos};
    ext_n = {1'b0, nos};
    ext_c = {{DW{1'b0}}, cin};
    case (op)
      OP_ADD:  acc = ext_n + ext_t;
      OP_ADDC: acc = ext_n + ext_t + ext_c;
      OP_SUB:  acc = ext_n - ext_t;
      OP_SUBB: acc = ext_n - ext_t - ext_c;
      OP_INC:  acc = ext_t + ONE;
      OP_DEC:  acc = ext_t - ONE;
      default: acc = ext_t;
    endcase
    res  = acc[DW-1:0];
    cout = acc[DW];
  end
endmodule

// File: rtl/stk_alu_logic.sv
module stk_alu_logic
  import stk_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] tos,
  input  logic [DW-1:0] nos,
  output logic [DW-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = nos & tos;
      OP_OR:   res = nos | tos;
      OP_XOR:  res = nos ^ tos;
      OP_NOT:  res = ~tos;
      default: res = tos;
    endcase
  end
endmodule

// File: rtl/stk_alu_shift.sv
module stk_alu_shift
  import stk_alu_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] tos,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int MSB = DW - 1;

  always_comb begin
    case (op)
      OP_SHL: begin res = {tos[MSB-1:0], 1'b0}; cout = tos[MSB]; end
      OP_SHR: begin res = {1'b0, tos[MSB:1]};   cout = tos[0];   end
      OP_ROL: begin res = {tos[MSB-1:0], cin};  cout = tos[MSB]; end
      OP_ROR: begin res = {cin, tos[MSB:1]};    cout = tos[0];   end
      default: begin res = tos; cout = cin; end
    endcase
  end
endmodule

// File: rtl/stk_alu4.sv
module stk_alu4
  import stk_alu_pkg::*;
#(
  parameter int DW  = 4,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  tos_in,
  input  logic [DW-1:0]  nos_in,
  input  logic           carry_in,
  output logic [DW-1:0]  res_out,
  output logic           carry_out,
  output logic           branch_out,
  output logic           flag_wr,
  output logic           pop_req
);
  alu_op_e       op_e;
  alu_cls_e      cls;
  logic [DW-1:0] ar_res, lg_res, sh_res, nxt_res;
  logic          ar_c, sh_c, nxt_c, nxt_b, is_pair;

  assign op_e = alu_op_e'(op_code[3:0]);

  always_comb begin
    case (op_e)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_INC, OP_DEC: cls = CLS_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_NOT:                    cls = CLS_LOGIC;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR:                   cls = CLS_SHIFT;
      default:                                          cls = CLS_NONE;
    endcase
    is_pair = (op_e <= OP_XOR);
  end

  stk_alu_arith #(.DW(DW)) u_arith (
    .op(op_e), .tos(tos_in), .nos(nos_in), .cin(carry_in),
    .res(ar_res), .cout(ar_c)
  );

  stk_alu_logic #(.DW(DW)) u_logic (
    .op(op_e), .tos(tos_in), .nos(nos_in), .res(lg_res)
  );

  stk_alu_shift #(.DW(DW)) u_shift (
    .op(op_e), .tos(tos_in), .cin(carry_in),
    .res(sh_res), .cout(sh_c)
  );

  always_comb begin
    case (cls)
      CLS_ARITH: begin nxt_res = ar_res; nxt_c = ar_c;     end
      CLS_LOGIC: begin nxt_res = lg_res; nxt_c = carry_in; end
      CLS_SHIFT: begin nxt_res = sh_res; nxt_c = sh_c;     end
      default:   begin nxt_res = res_out; nxt_c = carry_out; end
    endcase
    if (cls == CLS_SHIFT)
      nxt_b = sh_c;
    else
      nxt_b = (nxt_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out    <= '0;
      carry_out  <= 1'b0;
      branch_out <= 1'b0;
      flag_wr    <= 1'b0;
      pop_req    <= 1'b0;
    end else begin
      flag_wr <= 1'b0;
      pop_req <= 1'b0;
      if (op_valid && cls != CLS_NONE) begin
        res_out    <= nxt_res;
        carry_out  <= nxt_c;
        branch_out <= nxt_b;
        flag_wr    <= 1'b1;
        pop_req    <= is_pair;
      end
    end
  end
endmodule

// File: rtl/stk_alu4_chk.sv
module stk_alu4_chk #(
  parameter int DW  = 4,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [DW-1:0]  res_out,
  input logic           carry_out,
  input logic           branch_out,
  input logic           flag_wr,
  input logic           pop_req
);
  AST_STROBE_ON_OP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code < 14) |=> flag_wr); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!flag_wr && !pop_req && $stable(res_out) && $stable(carry_out))); // R10
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 14) |=> (!flag_wr && $stable(res_out) && $stable(branch_out))); // R11
  AST_POP_PAIR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 6) |=> pop_req); // R9
  AST_POP_UNARY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 7) |=> !pop_req); // R9
  AST_ZERO_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code <= 9) |=> (branch_out == (res_out == '0))); // R8
  AST_SHIFT_BRANCH: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 10 && op_code <= 13) |=> (branch_out == carry_out)); // R6
endmodule

bind stk_alu4 stk_alu4_chk #(.DW(DW), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .res_out(res_out), .carry_out(carry_out), .branch_out(branch_out),
  .flag_wr(flag_wr), .pop_req(pop_req)
);

// File: tb/test_stk_alu4.sv
module test_stk_alu4;
  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic [3:0] op_code, tos_in, nos_in;
  logic       carry_in;
  logic [3:0] res_out;
  logic       carry_out, branch_out, flag_wr, pop_req;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  int         op_q[$];

  always #2 clk = ~clk;

  stk_alu4 i_stk_alu4 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .tos_in(tos_in), .nos_in(nos_in), .carry_in(carry_in),
    .res_out(res_out), .carry_out(carry_out), .branch_out(branch_out),
    .flag_wr(flag_wr), .pop_req(pop_req)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // returns {1'b0, pop, branch, carry, res}
  function automatic logic [7:0] model(int op, int t, int n, int ci);
    int r, c, b, p, s;
    c = ci; r = t; p = (op <= 6) ? 1 : 0;
    case (op)
      0:  begin s = n + t;      r = s % 16; c = (s > 15) ? 1 : 0; end
      1:  begin s = n + t + ci; r = s % 16; c = (s > 15) ? 1 : 0; end
      2:  begin s = n - t;      r = (s + 32) % 16; c = (s < 0) ? 1 : 0; end
      3:  begin s = n - t - ci; r = (s + 32) % 16; c = (s < 0) ? 1 : 0; end
      4:  r = n & t;
      5:  r = n | t;
      6:  r = n ^ t;
      7:  r = 15 - t;
      8:  begin r = (t + 1) % 16; c = (t == 15) ? 1 : 0; end
      9:  begin r = (t + 15) % 16; c = (t == 0) ? 1 : 0; end
      10: begin r = (t * 2) % 16; c = t / 8; end
      11: begin r = t / 2; c = t % 2; end
      12: begin r = (t * 2) % 16 + ci; c = t / 8; end
      13: begin r = t / 2 + 8 * ci; c = t % 2; end
      default: ;
    endcase
    b = (op >= 10) ? c : ((r == 0) ? 1 : 0);
    return {1'b0, p[0], b[0], c[0], r[3:0]};
  endfunction

  function automatic string req_of(int op);
    if (op <= 1) return "R2";
    if (op <= 3) return "R3";
    if (op <= 7) return "R4";
    if (op <= 9) return "R5";
    if (op <= 11) return "R6";
    return "R7";
  endfunction

  task automatic drive_op(int op, int t, int n, int ci);
    @(negedge clk);
    op_valid = 1'b1;
    op_code  = op[3:0];
    tos_in   = t[3:0];
    nos_in   = n[3:0];
    carry_in = ci[0];
    if (op < 14) begin
      exp_q.push_back(model(op, t, n, ci));
      op_q.push_back(op);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && flag_wr) begin
      if (exp_q.size() == 0) begin
        check("R11", "unexpected flag_wr", 1, 0);
      end else begin
        logic [7:0] e;
        int op;
        e  = exp_q.pop_front();
        op = op_q.pop_front();
        check(req_of(op), "result", int'(res_out), int'(e[3:0]));
        check(req_of(op), "carry", int'(carry_out), int'(e[4]));
        check((op <= 9) ? "R8" : req_of(op), "branch", int'(branch_out), int'(e[5]));
        check("R9", "pop_req", int'(pop_req), int'(e[6]));
      end
    end
  end

  initial begin
    #(4 * 200000);
    check("WATCHDOG", "timeout", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] held;
    logic       held_c, held_b;
    rst = 1'b1; op_valid = 1'b0; op_code = '0; tos_in = '0; nos_in = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "res in reset", int'(res_out), 0);
    check("R1", "strobes in reset", int'({flag_wr, pop_req, carry_out, branch_out}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "res after reset", int'(res_out), 0);
    check("R1", "flag_wr after reset", int'(flag_wr), 0);

    // full sweep, back to back
    for (int op = 0; op < 14; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int t = 0; t < 16; t++)
          for (int n = 0; n < 16; n++)
            drive_op(op, t, n, ci);
    go_idle();
    repeat (3) @(negedge clk);
    check("R10", "queue drained", exp_q.size(), 0);

    // idle cycles hold outputs (R10)
    drive_op(0, 5, 9, 0);          // 14, c0
    go_idle();
    op_code = 4'd7; tos_in = 4'd3; // changes while idle must not matter
    @(negedge clk);
    held = res_out; held_c = carry_out; held_b = branch_out;
    repeat (3) begin
      @(negedge clk);
      check("R10", "idle res hold", int'(res_out), int'(held));
      check("R10", "idle flag_wr", int'(flag_wr), 0);
    end
    check("R10", "idle carry hold", int'(carry_out), int'(held_c));

    // reserved opcodes (R11)
    drive_op(14, 0, 0, 1);
    drive_op(15, 7, 7, 1);
    go_idle();
    @(negedge clk);
    check("R11", "reserved res hold", int'(res_out), int'(held));
    check("R11", "reserved carry hold", int'(carry_out), int'(held_c));
    check("R11", "reserved branch hold", int'(branch_out), int'(held_b));
    check("R11", "reserved no strobe", int'(flag_wr), 0);

    // single op latency and one-cycle strobe (R10)
    drive_op(8, 15, 0, 0);
    go_idle();
    check("R10", "strobe one cycle", int'(flag_wr), 1);
    @(negedge clk);
    check("R10", "strobe drops", int'(flag_wr), 0);
    check("R10", "queue empty", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule